// File: doc/BRIEF.md
# Ping-pong bulk endpoint buffer

This block is the data store behind one bulk endpoint of a USB device. It holds two equal banks that take turns. At any moment each bank belongs either to the local microcontroller or to the serial interface engine. The controller fills or empties its bank through a random-access byte port while the serial engine streams the other bank, so a transfer on the bus never waits for the controller. A single mode input sets the whole buffer to transmit (device to host) or to receive (host to device).

In transmit mode the controller writes a packet and commits it with a byte count. The bank then belongs to the engine, but it is not streamed out yet. The controller must first pulse a verify strobe to say that its integrity check on the data is complete. In receive mode the engine writes arriving bytes into the bank it owns. The last beat of a packet returns that bank to the controller together with the received length. When the controller holds both banks, an arriving packet is drained and discarded, and a NAK pulse is raised. The payload limit is 512 bytes at high speed and 64 bytes at full speed. A speed input selects the limit. Framing, PIDs and CRC are handled elsewhere.

Both stream interfaces use valid/ready. On the transmit side the buffer keeps `tx_valid`, `tx_data`, `tx_last` and `tx_empty` steady until a cycle with `tx_ready` high. On the receive side `rx_ready` is high for the whole of receive mode, so the buffer never pushes back on the engine. A packet it cannot store is consumed and dropped instead of stalled.

Top module: `bulk_pingpong_buf`

## Requirements
- R1: After reset both banks belong to the controller with zero length: `cpu_own`=1, `cpu_bank`=0, `cpu_len`=0, `tx_valid`=0, `rx_nak`=0.
- R2: `cpu_rdata` always shows, combinationally, the byte at `cpu_addr` in bank `cpu_bank`. A `cpu_wr` pulse stores `cpu_wdata` there only if the controller owns that bank. Otherwise the write is ignored.
- R3: A `cpu_commit` pulse on a controller-owned bank hands that bank to the engine and toggles `cpu_bank`. A commit while `cpu_own`=0 changes nothing.
- R4: In transmit mode a committed bank is not presented (`tx_valid` stays 0) until a `cpu_verify` pulse arrives while the engine owns its next bank. A verify pulse with no engine-owned bank is ignored.
- R5: A transmit bank streams bytes from address 0 upward, with `tx_last`=1 on the final byte. While `tx_ready`=0 the outputs hold steady.
- R6: In transmit mode the committed count is clamped to the payload limit: 512 when `speed_hs`=1, 64 when `speed_hs`=0.
- R7: A bank committed with count 0 is sent as one beat with `tx_last`=1 and `tx_empty`=1.
- R8: When a bank's last beat is accepted, ownership returns to the controller and the engine moves to the other bank. Banks therefore leave in commit order, alternating 0,1,0,...
- R9: In receive mode, data bytes go to addresses 0,1,2,... of the engine's bank. On the `rx_last` beat the bank returns to the controller and `cpu_len` shows the byte count once `cpu_bank` points at it.
- R10: Received bytes beyond the payload limit are discarded, and the reported count equals the limit.
- R11: When the controller holds both banks in receive mode, a whole arriving packet is discarded. `rx_nak` is 1 for exactly the one cycle after its last beat, and bank ownership and lengths are unchanged.
- R12: A beat with `rx_zlp`=1 carries no byte. A packet of only such a last beat hands back its bank with length 0.
- R13: `rx_ready` is 0 in transmit mode and 1 in receive mode. `tx_valid` is 0 in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_tx | input | 1 | 1 = transmit, 0 = receive; change only while the controller holds both banks |
| speed_hs | input | 1 | 1 = 512-byte limit, 0 = 64-byte limit |
| cpu_addr | input | AW (9) | Byte address within the controller's bank |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data at cpu_addr |
| cpu_commit | input | 1 | Hand the controller's bank to the engine |
| cpu_count | input | CW (10) | Packet length used on a transmit commit |
| cpu_verify | input | 1 | Releases the engine's next transmit bank |
| cpu_own | output | 1 | Controller owns bank cpu_bank |
| cpu_bank | output | 1 | Bank the controller port addresses |
| cpu_len | output | CW (10) | Length held for bank cpu_bank |
| tx_valid | output | 1 | Transmit beat available |
| tx_ready | input | 1 | Engine takes the transmit beat |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_empty | output | 1 | Beat of a zero-length packet |
| rx_valid | input | 1 | Receive beat present |
| rx_ready | output | 1 | Buffer accepts receive beats |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final beat of the packet |
| rx_zlp | input | 1 | Beat carries no byte |
| rx_nak | output | 1 | Refused-packet pulse |

## Verification
The hardest state to reach is a receive packet arriving while the controller holds both banks. Every bank first has to be committed, then filled, oversized or zero-length, and handed back without the controller returning it. The bench gets there with a fixed chain. It switches to receive, commits both banks, fills one with a short packet and the other with an oversized one, then returns one and takes the zero-length packet into it. That leaves the controller holding both banks when the refused packet is sent. A similar chain in transmit leaves both banks engine-owned, which exposes the ignored write and the ignored commit.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  typedef enum logic {
    OWN_CPU = 1'b0,
    OWN_SIE = 1'b1
  } owner_e;
endpackage

// File: rtl/bpp_bank_ram.sv
module bpp_bank_ram #(
  parameter int BANK_BYTES = 512,
  parameter int AW = $clog2(BANK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_we,
  input  logic          cpu_bank,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          sie_we,
  input  logic          sie_bank,
  input  logic [AW-1:0] sie_waddr,
  input  logic [7:0]    sie_wdata,
  input  logic [AW-1:0] sie_raddr,
  output logic [7:0]    sie_rdata
);
  logic [7:0] rd_cpu [2];
  logic [7:0] rd_sie [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [BANK_BYTES];
    always_ff @(posedge clk) begin
      if (cpu_we && cpu_bank == 1'(b))
        mem[cpu_addr] <= cpu_wdata;
      else if (sie_we && sie_bank == 1'(b))
        mem[sie_waddr] <= sie_wdata;
    end
    assign rd_cpu[b] = mem[cpu_addr];
    assign rd_sie[b] = mem[sie_raddr];
  end

  assign cpu_rdata = rd_cpu[cpu_bank];
  assign sie_rdata = rd_sie[sie_bank];

  // R2: the two ports never write the same bank in one cycle
  a_r2_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && sie_we && cpu_bank == sie_bank));
endmodule

// File: rtl/bpp_bank_ctl.sv
module bpp_bank_ctl
  import bpp_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_tx,
  input  logic [CW-1:0] lim,
  input  logic          cpu_commit,
  input  logic [CW-1:0] cpu_count,
  input  logic          cpu_verify,
  input  logic          sie_done,
  input  logic [CW-1:0] sie_count,
  output logic          cpu_ptr,
  output logic          sie_ptr,
  output logic          cpu_owned,
  output logic          sie_owned,
  output logic          sie_verified,
  output logic [CW-1:0] cpu_len,
  output logic [CW-1:0] sie_len
);
  owner_e        own [2];
  logic [CW-1:0] cnt [2];
  logic [1:0]    ver;

  logic          cpu_take, verify_ok;
  logic [CW-1:0] commit_len;

  assign cpu_take   = cpu_commit && own[cpu_ptr] == OWN_CPU;
  assign verify_ok  = cpu_verify && mode_tx && own[sie_ptr] == OWN_SIE;
  assign commit_len = !mode_tx ? '0 : (cpu_count > lim ? lim : cpu_count);

  for (genvar b = 0; b < 2; b++) begin : g_state
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        own[b] <= OWN_CPU;
        cnt[b] <= '0;
        ver[b] <= 1'b0;
      end else if (cpu_take && cpu_ptr == 1'(b)) begin
        own[b] <= OWN_SIE;
        cnt[b] <= commit_len;
        ver[b] <= 1'b0;
      end else if (sie_done && sie_ptr == 1'(b)) begin
        own[b] <= OWN_CPU;
        cnt[b] <= mode_tx ? '0 : sie_count;
        ver[b] <= 1'b0;
      end else if (verify_ok && sie_ptr == 1'(b)) begin
        ver[b] <= 1'b1;
      end
    end

    // R3: a bank changes owner only through a commit or an engine hand-back
    a_r3_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_take && cpu_ptr == 1'(b)) && !(sie_done && sie_ptr == 1'(b))
      |=> $stable(own[b]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_ptr <= 1'b0;
      sie_ptr <= 1'b0;
    end else begin
      cpu_ptr <= cpu_ptr ^ cpu_take;
      sie_ptr <= sie_ptr ^ sie_done;
    end
  end

  assign cpu_owned    = own[cpu_ptr] == OWN_CPU;
  assign sie_owned    = own[sie_ptr] == OWN_SIE;
  assign sie_verified = ver[sie_ptr];
  assign cpu_len      = cnt[cpu_ptr];
  assign sie_len      = cnt[sie_ptr];

  // R8: the engine only finishes a bank it owns
  a_r8_done_owned: assert property (@(posedge clk) disable iff (!rst_n)
    sie_done |-> own[sie_ptr] == OWN_SIE);
  // R6: a transmit bank never holds more than the limit in force at commit
  a_r6_commit_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_take && mode_tx |=> cnt[$past(cpu_ptr)] <= $past(lim));
endmodule

// File: rtl/bpp_tx_engine.sv
module bpp_tx_engine #(
  parameter int AW = 9,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] len,
  input  logic [7:0]    ram_data,
  output logic [AW-1:0] rd_idx,
  output logic          done,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_empty
);
  logic [AW-1:0] idx;

  assign tx_valid = go;
  assign tx_empty = len == '0;
  assign tx_last  = tx_empty || CW'(idx) == len - 1'b1;
  assign tx_data  = tx_empty ? 8'h00 : ram_data;
  assign rd_idx   = idx;
  assign done     = go && tx_ready && tx_last;

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (go && tx_ready)
      idx <= tx_last ? '0 : idx + 1'b1;
  end

  // R5: a stalled beat is held unchanged
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R5: the read index stays inside the committed length
  a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_empty || CW'(idx) < len);
endmodule

// File: rtl/bpp_rx_engine.sv
module bpp_rx_engine #(
  parameter int AW = 9,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          have_bank,
  input  logic [CW-1:0] lim,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_zlp,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          done,
  output logic [CW-1:0] done_cnt,
  output logic          nak
);
  logic [CW-1:0] idx;
  logic          in_pkt, dropping;
  logic          accept, drop_now;

  assign rx_ready = en;
  assign accept   = rx_valid && en;
  assign drop_now = in_pkt ? dropping : !have_bank;
  assign wr_en    = accept && !drop_now && !rx_zlp && idx < lim;
  assign wr_idx   = idx[AW-1:0];
  assign wr_data  = rx_data;
  assign done     = accept && rx_last && !drop_now;
  assign done_cnt = idx + CW'(wr_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      in_pkt   <= 1'b0;
      dropping <= 1'b0;
      nak      <= 1'b0;
    end else begin
      nak <= accept && rx_last && drop_now;
      if (accept) begin
        if (rx_last) begin
          idx      <= '0;
          in_pkt   <= 1'b0;
          dropping <= 1'b0;
        end else begin
          in_pkt   <= 1'b1;
          dropping <= drop_now;
          if (wr_en) idx <= idx + 1'b1;
        end
      end
    end
  end

  // R10: a completed packet never reports more than the limit
  a_r10_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_cnt <= lim);
  // R11: a refusal pulse follows the last beat of a packet
  a_r11_nak_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    nak |-> $past(rx_valid && rx_last));
endmodule

// File: rtl/bulk_pingpong_buf.sv
module bulk_pingpong_buf #(
  parameter int BANK_BYTES = 512,
  parameter int HS_MAX     = 512,
  parameter int FS_MAX     = 64,
  localparam int AW = $clog2(BANK_BYTES),
  localparam int CW = $clog2(BANK_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_tx,
  input  logic          speed_hs,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          cpu_commit,
  input  logic [CW-1:0] cpu_count,
  input  logic          cpu_verify,
  output logic          cpu_own,
  output logic          cpu_bank,
  output logic [CW-1:0] cpu_len,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_empty,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_zlp,
  output logic          rx_nak
);
  localparam logic [CW-1:0] LIM_HS = CW'(HS_MAX);
  localparam logic [CW-1:0] LIM_FS = CW'(FS_MAX);

  logic [CW-1:0] lim;
  logic          sie_ptr, sie_owned, sie_verified;
  logic [CW-1:0] sie_len;
  logic          tx_done, rx_done, sie_done;
  logic [CW-1:0] rx_cnt;
  logic [AW-1:0] tx_idx, rx_idx;
  logic          rx_we;
  logic [7:0]    rx_wdata, ram_rdata;

  assign lim      = speed_hs ? LIM_HS : LIM_FS;
  assign sie_done = tx_done || rx_done;

  bpp_bank_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .lim(lim),
    .cpu_commit(cpu_commit), .cpu_count(cpu_count), .cpu_verify(cpu_verify),
    .sie_done(sie_done), .sie_count(rx_cnt),
    .cpu_ptr(cpu_bank), .sie_ptr(sie_ptr), .cpu_owned(cpu_own),
    .sie_owned(sie_owned), .sie_verified(sie_verified),
    .cpu_len(cpu_len), .sie_len(sie_len)
  );

  bpp_bank_ram #(.BANK_BYTES(BANK_BYTES), .AW(AW)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_wr && cpu_own), .cpu_bank(cpu_bank), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .sie_we(rx_we), .sie_bank(sie_ptr), .sie_waddr(rx_idx),
    .sie_wdata(rx_wdata), .sie_raddr(tx_idx), .sie_rdata(ram_rdata)
  );

  bpp_tx_engine #(.AW(AW), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .go(mode_tx && sie_owned && sie_verified), .len(sie_len),
    .ram_data(ram_rdata), .rd_idx(tx_idx), .done(tx_done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_empty(tx_empty)
  );

  bpp_rx_engine #(.AW(AW), .CW(CW)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(!mode_tx), .have_bank(sie_owned), .lim(lim),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_zlp(rx_zlp),
    .wr_en(rx_we), .wr_idx(rx_idx), .wr_data(rx_wdata),
    .done(rx_done), .done_cnt(rx_cnt), .nak(rx_nak)
  );

  // R4: nothing leaves the buffer in transmit mode before verification
  a_r4_verified_only: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> sie_verified && sie_owned);
  // R13: direction exclusivity at the stream ports
  a_r13_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));
endmodule

// File: tb/bulk_pingpong_buf_test.sv
module bulk_pingpong_buf_test;
  localparam int AW = 9;
  localparam int CW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_tx = 1'b1, speed_hs = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_wr = 1'b0, cpu_commit = 1'b0, cpu_verify = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [CW-1:0] cpu_count = '0;
  logic [7:0]    cpu_rdata;
  logic          cpu_own, cpu_bank;
  logic [CW-1:0] cpu_len;
  logic          tx_valid, tx_last, tx_empty;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_data;
  logic          rx_valid = 1'b0, rx_last = 1'b0, rx_zlp = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, rx_nak;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  bulk_pingpong_buf uut (
    .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .speed_hs(speed_hs),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_commit(cpu_commit), .cpu_count(cpu_count),
    .cpu_verify(cpu_verify), .cpu_own(cpu_own), .cpu_bank(cpu_bank),
    .cpu_len(cpu_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .tx_empty(tx_empty),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .rx_zlp(rx_zlp), .rx_nak(rx_nak)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cpu_write(input int addr, input int data);
    @(negedge clk);
    cpu_addr = AW'(addr); cpu_wdata = 8'(data); cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic commit(input int count);
    @(negedge clk);
    cpu_count = CW'(count); cpu_commit = 1'b1;
    @(negedge clk);
    cpu_commit = 1'b0;
  endtask

  task automatic verify();
    @(negedge clk);
    cpu_verify = 1'b1;
    @(negedge clk);
    cpu_verify = 1'b0;
  endtask

  task automatic read_chk(input string req, input int addr, input int exp);
    @(negedge clk);
    cpu_addr = AW'(addr);
    #1 chk(req, cpu_rdata, exp);
  endtask

  task automatic tx_expect(input string req, input int n, input int base, input bit stall);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (stall && i == 1) begin
        tx_ready = 1'b0;
        #1 chk({req, " stall data"}, tx_data, (base + i) & 8'hFF);
        @(negedge clk);
        #1 chk({req, " held data"}, tx_data, (base + i) & 8'hFF);
        chk({req, " held valid"}, tx_valid, 1);
      end
      tx_ready = 1'b1;
      #1 chk({req, " data"}, tx_data, (base + i) & 8'hFF);
      chk({req, " last"}, tx_last, i == n - 1);
    end
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_send(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(base + i); rx_last = (i == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 cpu_own", cpu_own, 1);
    chk("R1 cpu_bank", cpu_bank, 0);
    chk("R1 cpu_len", cpu_len, 0);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 rx_nak", rx_nak, 0);
    chk("R13 rx_ready in tx mode", rx_ready, 0);
  endtask

  task automatic t_cpu_access();
    for (int i = 0; i < 4; i++) cpu_write(i, 8'h51 + i * 7);
    cpu_write(511, 8'hC3);
    for (int i = 0; i < 4; i++) read_chk("R2 readback", i, 8'h51 + i * 7);
    read_chk("R2 top address", 511, 8'hC3);
  endtask

  task automatic t_tx_gate();
    verify();
    chk("R4 stray verify", tx_valid, 0);
    for (int i = 0; i < 8; i++) cpu_write(i, 8'h30 + i);
    commit(8);
    chk("R3 bank toggled", cpu_bank, 1);
    chk("R3 other bank owned", cpu_own, 1);
    repeat (3) @(negedge clk);
    chk("R4 held before verify", tx_valid, 0);
    verify();
    #1 chk("R4 released", tx_valid, 1);
    tx_expect("R5", 8, 8'h30, 1'b1);
    #1 chk("R8 idle after send", tx_valid, 0);
  endtask

  task automatic t_tx_pingpong();
    for (int i = 0; i < 4; i++) cpu_write(i, 8'hA0 + i);
    commit(4);
    for (int i = 0; i < 3; i++) cpu_write(i, 8'hB0 + i);
    commit(3);
    #1 chk("R3 both given away", cpu_own, 0);
    cpu_write(0, 8'hEE);
    read_chk("R2 ignored write", 0, 8'hA0);
    commit(2);
    chk("R3 ignored commit", cpu_bank, 1);
    verify();
    tx_expect("R8 first bank", 4, 8'hA0, 1'b0);
    verify();
    tx_expect("R8 second bank", 3, 8'hB0, 1'b0);
    #1 chk("R8 returned", cpu_own, 1);
  endtask

  task automatic t_tx_clamp();
    int beats = 0;
    speed_hs = 1'b0;
    commit(100);
    verify();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      tx_ready = 1'b1;
      #1;
      if (tx_valid) begin
        beats++;
        if (tx_last) break;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R6 full speed clamp", beats, 64);
    speed_hs = 1'b1;
  endtask

  task automatic t_tx_zlp();
    commit(0);
    verify();
    #1 chk("R7 valid", tx_valid, 1);
    chk("R7 last", tx_last, 1);
    chk("R7 empty", tx_empty, 1);
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    #1 chk("R7 single beat", tx_valid, 0);
  endtask

  task automatic t_rx_basic();
    @(negedge clk);
    mode_tx = 1'b0;
    #1 chk("R13 rx_ready in rx mode", rx_ready, 1);
    commit(0);
    commit(0);
    chk("R13 no tx in rx mode", tx_valid, 0);
    rx_send(5, 8'h60);
    #1 chk("R9 owned", cpu_own, 1);
    chk("R9 bank", cpu_bank, 1);
    chk("R9 length", cpu_len, 5);
    read_chk("R9 first byte", 0, 8'h60);
    read_chk("R9 last byte", 4, 8'h64);
  endtask

  task automatic t_rx_oversize();
    speed_hs = 1'b0;
    rx_send(70, 8'h40);
    commit(0);
    chk("R10 bank", cpu_bank, 0);
    chk("R10 capped length", cpu_len, 64);
    read_chk("R10 byte at limit", 63, 8'h7F);
    speed_hs = 1'b1;
  endtask

  task automatic t_rx_zlp_nak();
    @(negedge clk);
    rx_valid = 1'b1; rx_last = 1'b1; rx_zlp = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_zlp = 1'b0;
    rx_send(3, 8'h11);
    #1 chk("R11 nak pulse", rx_nak, 1);
    chk("R11 length unchanged", cpu_len, 64);
    chk("R11 bank unchanged", cpu_bank, 0);
    @(negedge clk);
    #1 chk("R11 nak one cycle", rx_nak, 0);
    commit(0);
    chk("R12 empty packet bank", cpu_bank, 1);
    chk("R12 empty packet length", cpu_len, 0);
    chk("R12 owned", cpu_own, 1);
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cpu_access();
    t_tx_gate();
    t_tx_pingpong();
    t_tx_clamp();
    t_tx_zlp();
    t_rx_basic();
    t_rx_oversize();
    t_rx_zlp_nak();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule